// File: doc/BRIEF.md
# Reorder Buffer with Exception Flush

This block keeps in-flight instructions in program order while their results arrive in any order. A dispatch stage reserves the next free slot and receives the slot index as a tag. Execution units later write results back under that tag. Only the oldest entry may update architectural state: once it holds a result without a fault, its destination and value appear on a register-file write port and the slot is released. When the oldest entry carries a fault, nothing is written. The block pulses an exception strobe with the entry's PC and discards every in-flight entry.

A dependent instruction being dispatched can query a tag. If that entry holds a finished value that has not yet retired, the value is returned on a bypass port. A build option chooses whether a completion arriving in the same cycle is also visible on that port.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, and `rf_we`, `exc_flag` and `byp_hit` are 0.
- R2: An accepted dispatch (`disp_valid` and `disp_ready` both high) takes the slot shown on `disp_tag`. Successive accepted dispatches receive consecutive indices modulo DEPTH.
- R3: With DEPTH entries live, `disp_ready` is 0 and a dispatch request changes nothing.
- R4: A completion stores its value and fault bit only in the tagged entry. It never drives the write port directly.
- R5: When the oldest live entry is completed without a fault, `rf_we` is 1 in that cycle with that entry's destination on `rf_addr` and its value on `rf_data`. The entry is released at the clock edge, and at most one entry retires per cycle.
- R6: A completion is ignored if its tag names a slot that is not live, or a slot that has already completed, or if it arrives in a flush cycle.
- R7: When the oldest live entry is completed with a fault, `exc_flag` is 1 for one cycle with its PC on `exc_pc` and `rf_we` stays 0. Every entry is discarded, so the tail returns to the head and the next dispatch tag equals the faulting slot.
- R8: A completion of the oldest entry does not cause a retire in the same cycle. The retire happens in the following cycle.
- R9: `byp_hit` is 1, with the stored value on `byp_data`, when the slot named by `byp_tag` is live, completed and fault-free. Otherwise `byp_hit` and `byp_data` are 0.
- R10: With FWD_CMP=1, an accepted fault-free completion whose tag equals `byp_tag` hits the bypass in the same cycle with `cmp_data`.
- R11: `disp_ready` is 0 in a cycle where `exc_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | REG_W | Destination register of the dispatched instruction |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_ready | output | 1 | Dispatch is accepted this cycle |
| disp_tag | output | log2(DEPTH) | Slot assigned to the dispatch |
| cmp_valid | input | 1 | Completion write |
| cmp_tag | input | log2(DEPTH) | Slot being completed |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Completing instruction faulted |
| byp_tag | input | log2(DEPTH) | Slot queried by a dependent instruction |
| byp_hit | output | 1 | Queried slot holds a usable value |
| byp_data | output | DATA_W | Value of the queried slot |
| rf_we | output | 1 | Register-file write enable (retire) |
| rf_addr | output | REG_W | Register written at retire |
| rf_data | output | DATA_W | Value written at retire |
| exc_flag | output | 1 | Exception strobe, flush in progress |
| exc_pc | output | PC_W | PC of the faulting entry |

## Verification
The bench builds the block with DEPTH=4 and FWD_CMP=1. The small depth makes the full state, pointer wrap and flush-from-full occur many times within a short random run. The same-cycle forwarding variant lets R10 be checked against the stored-value path of R9. The random completions deliberately target dead and already-completed slots, which exercises R6 on every pattern.

// File: rtl/rob_pkg.sv
package rob_pkg;
   localparam int unsigned ROB_DEPTH_DFLT = 8;
   localparam int unsigned ROB_REG_W_DFLT = 5;
   localparam int unsigned ROB_DATA_W_DFLT = 32;
   localparam int unsigned ROB_PC_W_DFLT = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned PTR_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [PTR_W-1:0] head,
   output logic [PTR_W-1:0] tail,
   output logic [PTR_W-1:0] occ,
   output logic             full,
   output logic             empty
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
      end else if (flush) begin
         tail <= head;
      end else begin
         if (push) tail <= tail + PTR_W'(1);
         if (pop)  head <= head + PTR_W'(1);
      end
   end

   assign occ   = tail - head;
   assign full  = (occ == PTR_W'(DEPTH));
   assign empty = (head == tail);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PC_W   = 32,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [REG_W-1:0]  alloc_dest,
   input  logic [PC_W-1:0]   alloc_pc,
   input  logic              cmp_valid,
   input  logic [IDX_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic              cmp_exc,
   input  logic              rel,
   input  logic [IDX_W-1:0]  rel_idx,
   input  logic              flush,
   output logic              cmp_take,
   output logic [DEPTH-1:0]  busy_q,
   output logic [DEPTH-1:0]  done_q,
   output logic [DEPTH-1:0]  exc_q,
   output logic [REG_W-1:0]  dest_q [DEPTH],
   output logic [DATA_W-1:0] data_q [DEPTH],
   output logic [PC_W-1:0]   pc_q   [DEPTH]
);
   // a completion lands only on a live slot that has not yet finished
   assign cmp_take = cmp_valid && busy_q[cmp_tag] && !done_q[cmp_tag] && !flush;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic hit_alloc, hit_cmp, hit_rel;
      assign hit_alloc = alloc    && (alloc_idx == IDX_W'(g));
      assign hit_cmp   = cmp_take && (cmp_tag   == IDX_W'(g));
      assign hit_rel   = rel      && (rel_idx   == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q[g] <= 1'b0;
            done_q[g] <= 1'b0;
            exc_q[g]  <= 1'b0;
            dest_q[g] <= '0;
            data_q[g] <= '0;
            pc_q[g]   <= '0;
         end else if (flush) begin
            busy_q[g] <= 1'b0;
            done_q[g] <= 1'b0;
            exc_q[g]  <= 1'b0;
         end else if (hit_alloc) begin
            busy_q[g] <= 1'b1;
            done_q[g] <= 1'b0;
            exc_q[g]  <= 1'b0;
            dest_q[g] <= alloc_dest;
            pc_q[g]   <= alloc_pc;
         end else if (hit_rel) begin
            busy_q[g] <= 1'b0;
            done_q[g] <= 1'b0;
            exc_q[g]  <= 1'b0;
         end else if (hit_cmp) begin
            done_q[g] <= 1'b1;
            exc_q[g]  <= cmp_exc;
            data_q[g] <= cmp_data;
         end
      end
   end
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned PC_W   = 32,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic              empty,
   input  logic [IDX_W-1:0]  hidx,
   input  logic [DEPTH-1:0]  done_q,
   input  logic [DEPTH-1:0]  exc_q,
   input  logic [REG_W-1:0]  dest_q [DEPTH],
   input  logic [DATA_W-1:0] data_q [DEPTH],
   input  logic [PC_W-1:0]   pc_q   [DEPTH],
   output logic              rf_we,
   output logic [REG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              exc_flag,
   output logic [PC_W-1:0]   exc_pc,
   output logic              pop,
   output logic              flush
);
   logic head_done;
   assign head_done = !empty && done_q[hidx];

   always_comb begin
      rf_we    = head_done && !exc_q[hidx];
      exc_flag = head_done &&  exc_q[hidx];
      rf_addr  = dest_q[hidx];
      rf_data  = data_q[hidx];
      exc_pc   = exc_flag ? pc_q[hidx] : '0;
      pop      = rf_we;
      flush    = exc_flag;
   end
endmodule

// File: rtl/rob_bypass.sv
module rob_bypass #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned DATA_W  = 32,
   parameter bit          FWD_CMP = 1'b1,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic [IDX_W-1:0]  byp_tag,
   input  logic [DEPTH-1:0]  busy_q,
   input  logic [DEPTH-1:0]  done_q,
   input  logic [DEPTH-1:0]  exc_q,
   input  logic [DATA_W-1:0] data_q [DEPTH],
   input  logic              cmp_take,
   input  logic [IDX_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic              cmp_exc,
   output logic              byp_hit,
   output logic [DATA_W-1:0] byp_data
);
   logic stored_hit;
   assign stored_hit = busy_q[byp_tag] && done_q[byp_tag] && !exc_q[byp_tag];

   if (FWD_CMP) begin : g_fwd
      logic live_hit;
      assign live_hit = cmp_take && !cmp_exc && (cmp_tag == byp_tag);
      always_comb begin
         byp_hit  = live_hit || stored_hit;
         byp_data = live_hit ? cmp_data : (stored_hit ? data_q[byp_tag] : '0);
      end
   end else begin : g_stored
      logic              unused_fwd;
      assign unused_fwd = cmp_take ^ cmp_exc ^ (^cmp_tag) ^ (^cmp_data);
      always_comb begin
         byp_hit  = stored_hit;
         byp_data = stored_hit ? data_q[byp_tag] : '0;
      end
   end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
   parameter int unsigned DEPTH   = rob_pkg::ROB_DEPTH_DFLT,
   parameter int unsigned REG_W   = rob_pkg::ROB_REG_W_DFLT,
   parameter int unsigned DATA_W  = rob_pkg::ROB_DATA_W_DFLT,
   parameter int unsigned PC_W    = rob_pkg::ROB_PC_W_DFLT,
   parameter bit          FWD_CMP = 1'b1,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned PTR_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [REG_W-1:0]  disp_dest,
   input  logic [PC_W-1:0]   disp_pc,
   output logic              disp_ready,
   output logic [IDX_W-1:0]  disp_tag,
   input  logic              cmp_valid,
   input  logic [IDX_W-1:0]  cmp_tag,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic              cmp_exc,
   input  logic [IDX_W-1:0]  byp_tag,
   output logic              byp_hit,
   output logic [DATA_W-1:0] byp_data,
   output logic              rf_we,
   output logic [REG_W-1:0]  rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              exc_flag,
   output logic [PC_W-1:0]   exc_pc
);
   if (!rob_pkg::is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("rob_core: DEPTH must be a power of two and at least 2");
   end
   if (REG_W < 1 || DATA_W < 1 || PC_W < 1) begin : g_bad_width
      $error("rob_core: field widths must be positive");
   end

   logic [PTR_W-1:0]  head_ptr, tail_ptr, occ;
   logic              full, empty, push, pop, flush, cmp_take;
   logic [DEPTH-1:0]  busy_q, done_q, exc_q;
   logic [REG_W-1:0]  dest_q [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PC_W-1:0]   pc_q   [DEPTH];

   assign disp_ready = !full && !flush;
   assign push       = disp_valid && disp_ready;
   assign disp_tag   = tail_ptr[IDX_W-1:0];

   rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
      .head(head_ptr), .tail(tail_ptr), .occ(occ), .full(full), .empty(empty)
   );

   rob_entries #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_entries (
      .clk(clk), .rst_n(rst_n),
      .alloc(push), .alloc_idx(disp_tag), .alloc_dest(disp_dest), .alloc_pc(disp_pc),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
      .rel(pop), .rel_idx(head_ptr[IDX_W-1:0]), .flush(flush),
      .cmp_take(cmp_take), .busy_q(busy_q), .done_q(done_q), .exc_q(exc_q),
      .dest_q(dest_q), .data_q(data_q), .pc_q(pc_q)
   );

   rob_retire #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_retire (
      .empty(empty), .hidx(head_ptr[IDX_W-1:0]), .done_q(done_q), .exc_q(exc_q),
      .dest_q(dest_q), .data_q(data_q), .pc_q(pc_q),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .exc_flag(exc_flag), .exc_pc(exc_pc), .pop(pop), .flush(flush)
   );

   rob_bypass #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FWD_CMP(FWD_CMP)) u_bypass (
      .byp_tag(byp_tag), .busy_q(busy_q), .done_q(done_q), .exc_q(exc_q), .data_q(data_q),
      .cmp_take(cmp_take), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
      .byp_hit(byp_hit), .byp_data(byp_data)
   );
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PTR_W = $clog2(DEPTH) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic             rf_we,
   input logic             exc_flag,
   input logic [PTR_W-1:0] head_ptr,
   input logic [PTR_W-1:0] tail_ptr,
   input logic [PTR_W-1:0] occ
);
   // R3
   full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == PTR_W'(DEPTH)) |-> !disp_ready);

   // R2
   tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |=> (tail_ptr == $past(tail_ptr) + PTR_W'(1)));

   // R5
   head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> (head_ptr == $past(head_ptr) + PTR_W'(1)));

   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flag |=> (head_ptr == tail_ptr));

   // R7
   no_write_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && exc_flag));

   // R11
   flush_holds_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_flag |-> !disp_ready);
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_rob_chk (
   .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
   .rf_we(rf_we), .exc_flag(exc_flag),
   .head_ptr(head_ptr), .tail_ptr(tail_ptr), .occ(occ)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
module test_rob_core;
   localparam int D  = 4;
   localparam int RW = 5;
   localparam int DW = 16;
   localparam int PW = 16;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic [RW-1:0] disp_dest = '0;
   logic [PW-1:0] disp_pc = '0;
   logic          disp_ready;
   logic [IW-1:0] disp_tag;
   logic          cmp_valid = 1'b0;
   logic [IW-1:0] cmp_tag = '0;
   logic [DW-1:0] cmp_data = '0;
   logic          cmp_exc = 1'b0;
   logic [IW-1:0] byp_tag = '0;
   logic          byp_hit;
   logic [DW-1:0] byp_data;
   logic          rf_we;
   logic [RW-1:0] rf_addr;
   logic [DW-1:0] rf_data;
   logic          exc_flag;
   logic [PW-1:0] exc_pc;

   int n_checks = 0;
   int n_errors = 0;

   // reference model state
   int mhead = 0, mtail = 0;
   bit mbusy [D];
   bit mdone [D];
   bit mexc  [D];
   int mdest [D];
   int mdata [D];
   int mpc   [D];

   always #5 clk = ~clk;

   rob_core #(.DEPTH(D), .REG_W(RW), .DATA_W(DW), .PC_W(PW), .FWD_CMP(1'b1)) i_rob_core (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_dest(disp_dest), .disp_pc(disp_pc),
      .disp_ready(disp_ready), .disp_tag(disp_tag),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
      .byp_tag(byp_tag), .byp_hit(byp_hit), .byp_data(byp_data),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
      .exc_flag(exc_flag), .exc_pc(exc_pc)
   );

   task automatic check(input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic int mcount();
      return mtail - mhead;
   endfunction

   // one cycle: drive at negedge, compare, then advance model at posedge
   task automatic step(input bit dv, input int dd, input int dp,
                       input bit cv, input int ct, input int cd, input bit ce,
                       input int bt);
      int  hidx, ttag;
      bit  e_rf, e_fl, e_rdy, take, e_hit;
      int  e_bd;
      @(negedge clk);
      disp_valid = dv; disp_dest = RW'(dd); disp_pc = PW'(dp);
      cmp_valid = cv; cmp_tag = IW'(ct); cmp_data = DW'(cd); cmp_exc = ce;
      byp_tag = IW'(bt);
      #1;
      hidx  = mhead % D;
      ttag  = mtail % D;
      e_rf  = (mcount() != 0) && mdone[hidx] && !mexc[hidx];
      e_fl  = (mcount() != 0) && mdone[hidx] &&  mexc[hidx];
      e_rdy = (mcount() < D) && !e_fl;
      take  = cv && mbusy[ct] && !mdone[ct] && !e_fl;
      if (take && ct == bt && !ce) begin
         e_hit = 1'b1; e_bd = cd % (1 << DW);            // R10
      end else if (mbusy[bt] && mdone[bt] && !mexc[bt]) begin
         e_hit = 1'b1; e_bd = mdata[bt];                 // R9
      end else begin
         e_hit = 1'b0; e_bd = 0;
      end
      check("R3/R11 disp_ready", disp_ready, e_rdy);
      check("R2 disp_tag", disp_tag, ttag);
      check("R5/R8 rf_we", rf_we, e_rf);
      if (e_rf) begin
         check("R5 rf_addr", rf_addr, mdest[hidx]);
         check("R5 rf_data", rf_data, mdata[hidx]);
      end
      check("R7 exc_flag", exc_flag, e_fl);
      if (e_fl) check("R7 exc_pc", exc_pc, mpc[hidx]);
      check("R9/R10 byp_hit", byp_hit, e_hit);
      check("R9/R10 byp_data", byp_data, e_bd);
      @(posedge clk);
      if (e_fl) begin
         for (int i = 0; i < D; i++) begin
            mbusy[i] = 1'b0; mdone[i] = 1'b0; mexc[i] = 1'b0;
         end
         mtail = mhead;
      end else begin
         if (take) begin                                 // R4, R6
            mdone[ct] = 1'b1; mexc[ct] = ce; mdata[ct] = cd % (1 << DW);
         end
         if (e_rf) begin
            mbusy[hidx] = 1'b0; mdone[hidx] = 1'b0; mhead++;
         end
         if (dv && e_rdy) begin
            mbusy[ttag] = 1'b1; mdone[ttag] = 1'b0; mexc[ttag] = 1'b0;
            mdest[ttag] = dd % (1 << RW); mpc[ttag] = dp % (1 << PW);
            mtail++;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0b0b));
      for (int i = 0; i < D; i++) begin
         mbusy[i] = 0; mdone[i] = 0; mexc[i] = 0; mdest[i] = 0; mdata[i] = 0; mpc[i] = 0;
      end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 disp_ready", disp_ready, 1);
      check("R1 disp_tag", disp_tag, 0);
      check("R1 rf_we", rf_we, 0);
      check("R1 exc_flag", exc_flag, 0);
      check("R1 byp_hit", byp_hit, 0);

      // R2/R3: fill to full, then an extra dispatch must be refused
      for (int i = 0; i < D; i++) step(1, 3 + i, 'h100 + i, 0, 0, 0, 0, 0);
      step(1, 9, 'h1ff, 0, 0, 0, 0, 0);
      check("R3 full keeps tag", disp_tag, 0);
      // R4: completion of a young entry does not write the register file
      step(0, 0, 0, 1, 2, 'h2222, 0, 2);
      // R9: stored bypass of slot 2
      step(0, 0, 0, 0, 0, 0, 0, 2);
      // R6: second completion of slot 2 ignored
      step(0, 0, 0, 1, 2, 'hdead, 0, 2);
      // R8/R10: complete head, forwarded at once, retire only next cycle
      step(0, 0, 0, 1, 0, 'h1010, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      // R7: fault on the new head (slot 1) flushes slots 2 and 3
      step(0, 0, 0, 1, 1, 'h0bad, 1, 1);
      step(1, 7, 'h222, 0, 0, 0, 0, 2);
      step(0, 0, 0, 0, 0, 0, 0, 2);
      check("R7 tag after flush", disp_tag, 1);
      // R6: completion to a slot discarded by the flush is ignored
      step(0, 0, 0, 1, 3, 'h3333, 0, 3);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         bit dv, cv, ce;
         dv = ($urandom % 10) < 6;
         cv = ($urandom % 10) < 7;
         ce = ($urandom % 24) == 0;
         step(dv, $urandom % 32, $urandom % 65536, cv, $urandom % D,
              $urandom % 65536, ce, $urandom % D);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule